// File: doc/BRIEF.md
# Two-Bank Port Expander Register File

This block is the register file of a sixteen-pin port expander. The pins are split into two byte-wide banks: bank A holds pins 0 to 7 and bank B holds pins 8 to 15. A host reaches the registers over a byte-wide bus with an address load, a write strobe, a read strobe, write data and registered read data. Every logical register has a bank A byte at an even address and a bank B byte at the next odd address. The address is the register index shifted left by one, with the bank in bit 0, so a 16-bit value is stored little-endian.

The file holds these registers per bank: pin direction, input inversion, interrupt enable, compare default, interrupt control, pull-up enable and output latch. It also has one configuration byte that both banks share. The interrupt flags, the interrupt capture and the live port value come from outside and are read-only. The file drives the pin direction, the output latch values and the pull-up enables onto the pads. It also passes the interrupt set-up to a separate interrupt-detection block. When the host reads the port, or reads the capture while capture-read clearing is enabled, the file sends that block a one-cycle clear pulse for the bank that was read.

After an access the internal address pointer either moves to the next byte address or stays where it is, depending on one configuration bit. This lets the host stream the bank A and bank B bytes of a register, or whole ranges of registers, after a single address load.

Top module: `gpx_regfile`

## Requirements
- R1: Reset sets every direction bit to 1 (all pins are inputs). It clears the inversion, interrupt enable, compare default, interrupt control, pull-up, output latch and configuration registers, the address pointer and the read data.
- R2: The register indices are: direction 0, inversion 1, interrupt enable 2, compare default 3, interrupt control 4, configuration 5, pull-up 6, flag 7, capture 8, port 9 and output latch 10. The byte address is index*2 + bank. A write to any of the writable indices is returned unchanged by a later read of the same address, and the registers feeding the interrupt block appear on their outputs after the write edge.
- R3: pin_is_in shows the direction registers. A 1 marks an input, a 0 marks a driven pin, and pin_out carries the output latch.
- R4: pin_pu shows the pull-up registers bit for bit.
- R5: A read of the port address returns the pin_in byte of that bank XOR the inversion byte of that bank.
- R6: A write to the port address loads the output latch of that bank. A read of the latch address returns the latch contents, not the pins.
- R7: The flag and capture addresses return flag_in and cap_in. Writes to the flag, capture and port reads side are ignored: flag and capture stay equal to the inputs, and no other register changes.
- R8: There is one configuration byte, reached at address 0x0A and at address 0x0B. Bits 7 and 4 always read as 0. Bit 5 set stops the address from moving. Bit 0 set enables clearing on a capture read.
- R9: When configuration bit 5 is 0, every read or write moves the pointer to the next byte address, and after 0x15 the pointer goes to 0x00. A strobe without an address load uses the pointer.
- R10: When configuration bit 5 is 1, the pointer stays on the accessed address.
- R11: A read of the port address of a bank sets that bank's bit of intr_clr for exactly the cycle after the read (bit 0 is bank A, bit 1 is bank B).
- R12: A read of the capture address sets that bank's intr_clr bit only when configuration bit 0 is 1.
- R13: Addresses 0x16 to 0x1F read as 0x00 and ignore writes.
- R14: Read data appears on host_rdata in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ld | input | 1 | Load host_addr as the access address |
| host_addr | input | 5 | Byte address used when host_ld is high |
| host_wr | input | 1 | Write strobe, one byte per cycle |
| host_rd | input | 1 | Read strobe, one byte per cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Synchronised pin levels |
| flag_in | input | 16 | Interrupt flags from the detection block |
| cap_in | input | 16 | Captured pin levels from the detection block |
| pin_is_in | output | 16 | 1 = pin is an input, 0 = pin is driven |
| pin_out | output | 16 | Output latch values |
| pin_pu | output | 16 | Weak pull-up enables |
| ien_q | output | 16 | Interrupt enable per pin |
| cmp_q | output | 16 | Compare default per pin |
| ictl_q | output | 16 | Interrupt control per pin |
| cfg_q | output | 8 | Shared configuration byte |
| intr_clr | output | 2 | One-cycle clear pulse per bank |

## Verification
The assertions assume that host_rd and host_wr are never high in the same cycle. They also assume that reset is held high from time zero until the first clock edge, so the pointer and the latch properties start from known values. The stimulus changes every input only on the falling clock edge and never raises both strobes together. It holds pin_in, flag_in and cap_in steady for the whole read cycle in which they are sampled, so each expected byte is fixed before the rising edge that captures it.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int IDX_W = 4;

  localparam logic [IDX_W-1:0] RI_DIR  = 4'd0;
  localparam logic [IDX_W-1:0] RI_POL  = 4'd1;
  localparam logic [IDX_W-1:0] RI_IEN  = 4'd2;
  localparam logic [IDX_W-1:0] RI_CMP  = 4'd3;
  localparam logic [IDX_W-1:0] RI_ICTL = 4'd4;
  localparam logic [IDX_W-1:0] RI_CFG  = 4'd5;
  localparam logic [IDX_W-1:0] RI_PUP  = 4'd6;
  localparam logic [IDX_W-1:0] RI_FLG  = 4'd7;
  localparam logic [IDX_W-1:0] RI_CAP  = 4'd8;
  localparam logic [IDX_W-1:0] RI_PRT  = 4'd9;
  localparam logic [IDX_W-1:0] RI_LAT  = 4'd10;
  localparam logic [IDX_W-1:0] RI_LAST = RI_LAT;

  localparam int CFG_ICC     = 0;
  localparam int CFG_SEQ_OFF = 5;
  localparam logic [7:0] CFG_MASK = 8'h6F;
endpackage

// File: rtl/gpx_addr_ptr.sv
module gpx_addr_ptr #(
  parameter int ADDR_W    = 5,
  parameter int LAST_ADDR = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              access,
  input  logic              seq_en,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] ptr_q
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_ADDR);

  logic [ADDR_W-1:0] next_addr;

  always_comb begin
    acc_addr  = ld ? ld_addr : ptr_q;
    next_addr = (acc_addr >= LAST) ? '0 : acc_addr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      ptr_q <= '0;
    else if (access)
      ptr_q <= seq_en ? next_addr : acc_addr;
    else if (ld)
      ptr_q <= ld_addr;
  end

  // R9: stepping past the last address returns to zero
  a_r9_wrap: assert property (@(posedge clk) disable iff (rst)
    (access && seq_en && acc_addr == LAST) |=> (ptr_q == '0));

  // R10: with stepping disabled the pointer stays on the accessed address
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (access && !seq_en) |=> (ptr_q == $past(acc_addr)));
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
  import gpx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     pin_in,
  input  logic [W-1:0]     flag_in,
  input  logic [W-1:0]     cap_in,
  output logic [W-1:0]     rd_byte,
  output logic [W-1:0]     dir_q,
  output logic [W-1:0]     ien_q,
  output logic [W-1:0]     cmp_q,
  output logic [W-1:0]     ictl_q,
  output logic [W-1:0]     pup_q,
  output logic [W-1:0]     lat_q
);
  logic [W-1:0] pol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '1;
      pol_q  <= '0;
      ien_q  <= '0;
      cmp_q  <= '0;
      ictl_q <= '0;
      pup_q  <= '0;
      lat_q  <= '0;
    end else if (wr) begin
      case (idx)
        RI_DIR:         dir_q  <= wdata;
        RI_POL:         pol_q  <= wdata;
        RI_IEN:         ien_q  <= wdata;
        RI_CMP:         cmp_q  <= wdata;
        RI_ICTL:        ictl_q <= wdata;
        RI_PUP:         pup_q  <= wdata;
        RI_PRT, RI_LAT: lat_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      RI_DIR:  rd_byte = dir_q;
      RI_POL:  rd_byte = pol_q;
      RI_IEN:  rd_byte = ien_q;
      RI_CMP:  rd_byte = cmp_q;
      RI_ICTL: rd_byte = ictl_q;
      RI_PUP:  rd_byte = pup_q;
      RI_FLG:  rd_byte = flag_in;
      RI_CAP:  rd_byte = cap_in;
      RI_PRT:  rd_byte = pin_in ^ pol_q;
      RI_LAT:  rd_byte = lat_q;
      default: rd_byte = '0;
    endcase
  end

  // R1: reset leaves every pin an input with a cleared latch
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (dir_q == '1 && lat_q == '0 && pup_q == '0));

  // R6: a port write lands in the output latch
  a_r6_port_to_latch: assert property (@(posedge clk) disable iff (rst)
    (wr && idx == RI_PRT) |=> (lat_q == $past(wdata)));
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_ld,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic                    host_wr,
  input  logic                    host_rd,
  input  logic [7:0]              host_wdata,
  output logic [7:0]              host_rdata,
  input  logic [2*BANK_W-1:0]     pin_in,
  input  logic [2*BANK_W-1:0]     flag_in,
  input  logic [2*BANK_W-1:0]     cap_in,
  output logic [2*BANK_W-1:0]     pin_is_in,
  output logic [2*BANK_W-1:0]     pin_out,
  output logic [2*BANK_W-1:0]     pin_pu,
  output logic [2*BANK_W-1:0]     ien_q,
  output logic [2*BANK_W-1:0]     cmp_q,
  output logic [2*BANK_W-1:0]     ictl_q,
  output logic [7:0]              cfg_q,
  output logic [1:0]              intr_clr
);
  localparam int NBANK     = 2;
  localparam int LAST_ADDR = 2 * int'(RI_LAST) + 1;

  logic              access;
  logic              seq_en;
  logic [ADDR_W-1:0] acc_addr;
  logic [ADDR_W-1:0] ptr_q;
  logic [IDX_W-1:0]  acc_idx;
  logic              acc_bank;
  logic              acc_valid;
  logic [7:0]        rd_mux;
  logic [BANK_W-1:0] bank_rd [NBANK];
  logic [1:0]        clr_next;

  assign access   = host_rd | host_wr;
  assign seq_en   = ~cfg_q[CFG_SEQ_OFF];
  assign acc_idx  = IDX_W'(acc_addr >> 1);
  assign acc_bank = acc_addr[0];
  assign acc_valid = (acc_addr >> 1) <= ADDR_W'(RI_LAST);

  gpx_addr_ptr #(
    .ADDR_W   (ADDR_W),
    .LAST_ADDR(LAST_ADDR)
  ) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .ld      (host_ld),
    .ld_addr (host_addr),
    .access  (access),
    .seq_en  (seq_en),
    .acc_addr(acc_addr),
    .ptr_q   (ptr_q)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = host_wr && acc_valid && (acc_bank == 1'(b));

    gpx_bank #(.W(BANK_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .wr     (bank_wr),
      .idx    (acc_idx),
      .wdata  (host_wdata),
      .pin_in (pin_in[b*BANK_W +: BANK_W]),
      .flag_in(flag_in[b*BANK_W +: BANK_W]),
      .cap_in (cap_in[b*BANK_W +: BANK_W]),
      .rd_byte(bank_rd[b]),
      .dir_q  (pin_is_in[b*BANK_W +: BANK_W]),
      .ien_q  (ien_q[b*BANK_W +: BANK_W]),
      .cmp_q  (cmp_q[b*BANK_W +: BANK_W]),
      .ictl_q (ictl_q[b*BANK_W +: BANK_W]),
      .pup_q  (pin_pu[b*BANK_W +: BANK_W]),
      .lat_q  (pin_out[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    if (!acc_valid)
      rd_mux = '0;
    else if (acc_idx == RI_CFG)
      rd_mux = cfg_q;
    else
      rd_mux = 8'(bank_rd[acc_bank]);

    clr_next = '0;
    if (host_rd && acc_valid &&
        (acc_idx == RI_PRT || (acc_idx == RI_CAP && cfg_q[CFG_ICC])))
      clr_next[acc_bank] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      host_rdata <= '0;
      intr_clr   <= '0;
    end else begin
      if (host_wr && acc_valid && acc_idx == RI_CFG)
        cfg_q <= host_wdata & CFG_MASK;
      if (host_rd)
        host_rdata <= rd_mux;
      intr_clr <= clr_next;
    end
  end

  // R11: a clear pulse only follows a read strobe
  a_r11_clr_after_read: assert property (@(posedge clk) disable iff (rst)
    (intr_clr != 2'b00) |-> $past(host_rd));

  // R11: at most one bank is cleared per cycle
  a_r11_one_bank: assert property (@(posedge clk) disable iff (rst)
    $onehot0(intr_clr));

  // R14: read data only moves after a read strobe
  a_r14_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));

  // R8: reserved configuration bits never become set
  a_r8_cfg_reserved: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> (cfg_q[7] == 1'b0 && cfg_q[4] == 1'b0));
endmodule

// File: tb/tb_gpx_regfile.sv
`timescale 1ns/1ps
module tb_gpx_regfile;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        host_ld = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [15:0] pin_in = '0, flag_in = '0, cap_in = '0;
  logic [15:0] pin_is_in, pin_out, pin_pu, ien_q, cmp_q, ictl_q;
  logic [7:0]  cfg_q;
  logic [1:0]  intr_clr;

  gpx_regfile dut (
    .clk(clk), .rst(rst), .host_ld(host_ld), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .pin_in(pin_in), .flag_in(flag_in),
    .cap_in(cap_in), .pin_is_in(pin_is_in), .pin_out(pin_out),
    .pin_pu(pin_pu), .ien_q(ien_q), .cmp_q(cmp_q), .ictl_q(ictl_q),
    .cfg_q(cfg_q), .intr_clr(intr_clr)
  );

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] shw [0:10][0:1];
  logic [7:0] cfg_sh;
  logic [4:0] ptr_m;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [4:0] a);
    int i = int'(a[4:1]);
    int b = int'(a[0]);
    if (i > 10) return 8'h00;
    case (i)
      5: return cfg_sh & 8'h6F;
      7: return flag_in[b*8 +: 8];
      8: return cap_in[b*8 +: 8];
      9: return pin_in[b*8 +: 8] ^ shw[1][b];
      default: return shw[i][b];
    endcase
  endfunction

  task automatic model_access(logic [4:0] a, bit is_wr, logic [7:0] d);
    int i = int'(a[4:1]);
    int b = int'(a[0]);
    if (!cfg_sh[5]) ptr_m = (a >= 5'd21) ? 5'd0 : a + 5'd1;
    else            ptr_m = a;
    if (is_wr && i <= 10) begin
      if (i == 5)               cfg_sh = d & 8'h6F;
      else if (i == 9)          shw[10][b] = d;
      else if (i != 7 && i != 8) shw[i][b] = d;
    end
  endtask

  task automatic check_pins();
    check("R3 direction", pin_is_in, {shw[0][1], shw[0][0]});
    check("R3 R6 latch drive", pin_out, {shw[10][1], shw[10][0]});
    check("R4 pull-up", pin_pu, {shw[6][1], shw[6][0]});
    check("R2 enable out", ien_q, {shw[2][1], shw[2][0]});
    check("R2 compare out", cmp_q, {shw[3][1], shw[3][0]});
    check("R2 control out", ictl_q, {shw[4][1], shw[4][0]});
    check("R8 cfg out", {8'h00, cfg_q}, {8'h00, cfg_sh});
  endtask

  task automatic do_wr(bit ld, logic [4:0] a, logic [7:0] d);
    logic [4:0] ea = ld ? a : ptr_m;
    host_ld = ld; host_addr = a; host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_ld = 1'b0; host_wr = 1'b0;
    model_access(ea, 1'b1, d);
    check_pins();
  endtask

  task automatic do_rd(bit ld, logic [4:0] a, string req);
    logic [4:0] ea = ld ? a : ptr_m;
    logic [7:0] e = exp_rd(ea);
    logic [1:0] ec = 2'b00;
    if (ea[4:1] == 4'd9 || (ea[4:1] == 4'd8 && cfg_sh[0])) ec[ea[0]] = 1'b1;
    host_ld = ld; host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_ld = 1'b0; host_rd = 1'b0;
    check(req, {8'h00, host_rdata}, {8'h00, e});
    check("R11 R12 clear pulse", {14'h0, intr_clr}, {14'h0, ec});
    model_access(ea, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i <= 10; i++) begin
      shw[i][0] = 8'h00; shw[i][1] = 8'h00;
    end
    shw[0][0] = 8'hFF; shw[0][1] = 8'hFF;
    cfg_sh = 8'h00; ptr_m = 5'd0;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R13 invalid addresses read zero
    check("R14 rdata reset", {8'h00, host_rdata}, 16'h0000);
    check_pins();
    for (int a = 0; a < 32; a++) do_rd(1'b1, 5'(a), a > 21 ? "R13 invalid read" : "R1 reset read");

    // R2 write/read sweep over writable registers
    for (int k = 0; k < 7; k++) begin
      int idx = (k < 5) ? k : ((k == 5) ? 6 : 10);
      for (int b = 0; b < 2; b++)
        for (int p = 0; p < 6; p++) begin
          logic [7:0] d = 8'((p * 75) ^ (idx << 4) ^ b);
          do_wr(1'b1, 5'(idx * 2 + b), d);
          do_rd(1'b1, 5'(idx * 2 + b), "R2 readback");
        end
    end

    // R8 shared configuration byte
    for (int p = 0; p < 8; p++) begin
      do_wr(1'b1, 5'(10 + (p & 1)), 8'(p * 41 + 7));
      do_rd(1'b1, 5'd10, "R8 cfg bank A");
      do_rd(1'b1, 5'd11, "R8 cfg bank B");
    end
    do_wr(1'b1, 5'd10, 8'h00);

    // R5 port read with inversion
    do_wr(1'b1, 5'd2, 8'h0F);
    do_wr(1'b1, 5'd3, 8'hF0);
    for (int k = 0; k < 8; k++) begin
      pin_in = 16'(k * 16'h1357) ^ 16'hA0C3;
      do_rd(1'b1, 5'd18, "R5 port A");
      do_rd(1'b1, 5'd19, "R5 port B");
    end

    // R6 port write goes to latch; latch read returns latch
    do_wr(1'b1, 5'd18, 8'h3C);
    do_wr(1'b1, 5'd19, 8'hC3);
    pin_in = 16'h0000;
    do_rd(1'b1, 5'd20, "R6 latch A");
    do_rd(1'b1, 5'd21, "R6 latch B");

    // R7 flag/capture read-only, R13 invalid writes
    for (int k = 0; k < 4; k++) begin
      flag_in = 16'(k * 16'h2345) ^ 16'h5A5A;
      cap_in  = 16'(k * 16'h1111) ^ 16'h0F0F;
      do_wr(1'b1, 5'd14, 8'hFF);
      do_wr(1'b1, 5'd17, 8'h00);
      do_rd(1'b1, 5'd14, "R7 flag A");
      do_rd(1'b1, 5'd15, "R7 flag B");
      do_rd(1'b1, 5'd16, "R7 capture A");
      do_rd(1'b1, 5'd17, "R7 capture B");
    end
    do_wr(1'b1, 5'd22, 8'hFF);
    do_wr(1'b1, 5'd31, 8'hAA);
    do_rd(1'b1, 5'd22, "R13 invalid after write");

    // R9 sequential stepping and wrap
    do_rd(1'b1, 5'd18, "R9 burst start");
    for (int k = 0; k < 6; k++) do_rd(1'b0, 5'd0, "R9 burst step");
    do_wr(1'b1, 5'd20, 8'h81);
    do_wr(1'b0, 5'd0, 8'h42);
    do_wr(1'b0, 5'd0, 8'hE7);
    do_wr(1'b0, 5'd0, 8'h18);
    do_rd(1'b1, 5'd0, "R9 wrapped write A");
    do_rd(1'b0, 5'd0, "R9 wrapped write B");

    // R10 stepping disabled
    do_wr(1'b1, 5'd10, 8'h20);
    do_rd(1'b1, 5'd0, "R10 hold start");
    for (int k = 0; k < 3; k++) do_rd(1'b0, 5'd0, "R10 hold");
    do_wr(1'b1, 5'd20, 8'h11);
    do_wr(1'b0, 5'd0, 8'h22);
    do_wr(1'b0, 5'd0, 8'h33);
    do_rd(1'b1, 5'd21, "R10 neighbour untouched");

    // R12 capture-read clearing, R11 port-read clearing
    do_wr(1'b1, 5'd10, 8'h21);
    do_rd(1'b1, 5'd16, "R12 capture A icc=1");
    do_rd(1'b1, 5'd17, "R12 capture B icc=1");
    do_wr(1'b1, 5'd10, 8'h00);
    do_rd(1'b1, 5'd16, "R12 capture A icc=0");
    do_rd(1'b1, 5'd18, "R11 port A");
    do_rd(1'b1, 5'd19, "R11 port B");
    do_rd(1'b1, 5'd0, "R11 no clear");
    repeat (2) @(negedge clk);
    check("R11 pulse one cycle", {14'h0, intr_clr}, 16'h0000);
    check("R14 rdata held", {8'h00, host_rdata}, {8'h00, shw[0][0]});

    // R1 reset again restores defaults
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i <= 10; i++) begin
      shw[i][0] = 8'h00; shw[i][1] = 8'h00;
    end
    shw[0][0] = 8'hFF; shw[0][1] = 8'hFF;
    cfg_sh = 8'h00; ptr_m = 5'd0;
    check_pins();
    do_rd(1'b0, 5'd0, "R1 pointer reset");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule